// File: doc/BRIEF.md
# Three-Output Masked Event Interrupt Controller

The block collects 96 single-bit hardware event lines into three 32-bit status words. A rising edge on an event line latches a 1 in that event's status bit. Software acknowledges the event by writing a 1 to the same bit. Three independent mask banks each hold one 32-bit mask word for every status word. Each bank drives one interrupt line, so a single event can be steered to none, one, two or all three lines.

A simple 32-bit register port gives read and write access to the status words and the mask words. For each interrupt line, a helper output reports the lowest-numbered event that is both pending and enabled for that line, together with a valid flag. The interrupt lines and the helper outputs are registered.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, every status bit and every mask bit reads 0, `irq_o` is 3'b000 and every `pend_valid_o` bit is 0.
- R2: A 0-to-1 transition on `event_i[e]` sets status word `e/32`, bit `e%32`. The new value is readable in the cycle after the clock edge that samples the transition. A line held high sets its bit only once, and the bit does not return after it is cleared until the line falls and rises again.
- R3: A write to status word `w` (byte address `4*w`) clears every bit for which `wdata_i` holds a 1. Bits written with 0 keep their value.
- R4: If an event rises in the same cycle as a write of 1 to its status bit, the bit stays set.
- R5: The register port decodes `addr_i[5:4]` as the region (0 = status, 1/2/3 = mask bank for `irq_o[0]`/`irq_o[1]`/`irq_o[2]`) and `addr_i[3:2]` as the word (0..2). Mask words are written whole and read back unchanged. Word 3 of any region reads 0, and writes to it have no effect.
- R6: `irq_o[g]` is high exactly when some status word ANDed with the matching mask word of bank `g` is nonzero. It is registered and follows a change of status or mask one clock edge later.
- R7: `pend_idx_o[7*g +: 7]` is the lowest set position of the 96-bit vector (status AND bank `g`), numbered bit + 32 × word, so word 0 bit 0 is the highest priority. `pend_valid_o[g]` marks it valid. Both have the same timing as `irq_o`.
- R8: The three banks act independently, so one event enabled in several banks raises every corresponding line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 96 | Event lines; a rising edge marks an event |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 3 | Interrupt lines, one per mask bank |
| pend_valid_o | output | 3 | Pending-event index valid, one per line |
| pend_idx_o | output | 21 | Lowest pending enabled event index, 7 bits per line |

## Verification
A stimulus applied just after clock edge N reaches the status or mask registers at edge N+1. `rdata_o` therefore shows the new value in the half-cycle after N+1, while `irq_o`, `pend_valid_o` and `pend_idx_o` move only at edge N+2. The driver pushes each expected value onto the scoreboard tagged with that due cycle. The monitor compares values only at the falling edge of their due cycle. One extra item checks that an interrupt line is still low at N+1, which pins the one-edge register delay.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_WORDS = 3;
  localparam int unsigned NUM_GRP   = 3;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned WSEL_W    = 2;

  typedef enum logic [1:0] {
    RGN_STATUS = 2'd0,
    RGN_GRP0   = 2'd1,
    RGN_GRP1   = 2'd2,
    RGN_GRP2   = 2'd3
  } region_e;
endpackage

// File: rtl/evt_status.sv
module evt_status #(
  parameter int unsigned NUM_EVT = 96
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] event_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] status_o,
  output logic [NUM_EVT-1:0] set_o
);
  logic [NUM_EVT-1:0] evt_q, status_q;

  assign set_o    = event_i & ~evt_q;
  assign status_o = status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q    <= '0;
      status_q <= '0;
    end else begin
      evt_q    <= event_i;
      // set has priority over clear
      status_q <= (status_q & ~clr_i) | set_o;
    end
  end
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 3,
  parameter int unsigned WSEL_W    = 2,
  localparam int unsigned NUM_EVT  = WORD_W * NUM_WORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [WSEL_W-1:0]  wr_word_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [NUM_EVT-1:0] mask_o
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q <= '0;
      else if (wr_en_i && wr_word_i == WSEL_W'(w))  word_q <= wdata_i;
    end
    assign mask_o[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/evt_route.sv
module evt_route #(
  parameter int unsigned NUM_EVT = 96,
  localparam int unsigned IDX_W  = $clog2(NUM_EVT)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] status_i,
  input  logic [NUM_EVT-1:0] mask_i,
  output logic               irq_o,
  output logic               pend_valid_o,
  output logic [IDX_W-1:0]   pend_idx_o
);
  logic [NUM_EVT-1:0] hit;
  logic               any_d;
  logic [IDX_W-1:0]   idx_d;
  logic               irq_q;
  logic [IDX_W-1:0]   idx_q;

  assign hit   = status_i & mask_i;
  assign any_d = |hit;

  // downward scan leaves the lowest set position
  always_comb begin
    idx_d = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (hit[i]) idx_d = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      idx_q <= '0;
    end else begin
      irq_q <= any_d;
      idx_q <= idx_d;
    end
  end

  assign irq_o        = irq_q;
  assign pend_valid_o = irq_q;
  assign pend_idx_o   = idx_q;
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORD_W_P    = WORD_W,
  parameter int unsigned NUM_WORDS_P = NUM_WORDS,
  parameter int unsigned NUM_GRP_P   = NUM_GRP,
  localparam int unsigned NUM_EVT    = WORD_W_P * NUM_WORDS_P,
  localparam int unsigned IDX_W      = $clog2(NUM_EVT)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_EVT-1:0]           event_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [WORD_W_P-1:0]          wdata_i,
  output logic [WORD_W_P-1:0]          rdata_o,
  output logic [NUM_GRP_P-1:0]         irq_o,
  output logic [NUM_GRP_P-1:0]         pend_valid_o,
  output logic [NUM_GRP_P*IDX_W-1:0]   pend_idx_o
);
  logic [1:0]             rgn;
  logic [WSEL_W-1:0]      wsel;
  logic                   word_ok;
  logic [NUM_EVT-1:0]     clr_vec;
  logic [NUM_EVT-1:0]     status_q;
  logic [NUM_EVT-1:0]     set_vec;
  logic [NUM_GRP_P*NUM_EVT-1:0] mask_flat;

  assign rgn     = addr_i[5:4];
  assign wsel    = addr_i[3:2];
  assign word_ok = 32'(wsel) < NUM_WORDS_P;

  for (genvar w = 0; w < NUM_WORDS_P; w++) begin : g_clr
    assign clr_vec[w*WORD_W_P +: WORD_W_P] =
      (we_i && rgn == RGN_STATUS && wsel == WSEL_W'(w)) ? wdata_i : '0;
  end

  evt_status #(.NUM_EVT(NUM_EVT)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (event_i),
    .clr_i    (clr_vec),
    .status_o (status_q),
    .set_o    (set_vec)
  );

  for (genvar g = 0; g < NUM_GRP_P; g++) begin : g_grp
    logic bank_we;
    assign bank_we = we_i && word_ok && rgn == 2'(g + 1);

    evt_mask_bank #(
      .WORD_W    (WORD_W_P),
      .NUM_WORDS (NUM_WORDS_P),
      .WSEL_W    (WSEL_W)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (bank_we),
      .wr_word_i (wsel),
      .wdata_i   (wdata_i),
      .mask_o    (mask_flat[g*NUM_EVT +: NUM_EVT])
    );

    evt_route #(.NUM_EVT(NUM_EVT)) u_route (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .status_i     (status_q),
      .mask_i       (mask_flat[g*NUM_EVT +: NUM_EVT]),
      .irq_o        (irq_o[g]),
      .pend_valid_o (pend_valid_o[g]),
      .pend_idx_o   (pend_idx_o[g*IDX_W +: IDX_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (word_ok) begin
      for (int w = 0; w < NUM_WORDS_P; w++) begin
        if (wsel == WSEL_W'(w)) begin
          if (rgn == RGN_STATUS) rdata_o = status_q[w*WORD_W_P +: WORD_W_P];
          for (int g = 0; g < NUM_GRP_P; g++) begin
            if (rgn == 2'(g + 1))
              rdata_o = mask_flat[g*NUM_EVT + w*WORD_W_P +: WORD_W_P];
          end
        end
      end
    end
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int unsigned WORD_W_P    = 32,
  parameter int unsigned NUM_WORDS_P = 3,
  parameter int unsigned NUM_GRP_P   = 3,
  localparam int unsigned NUM_EVT    = WORD_W_P * NUM_WORDS_P,
  localparam int unsigned IDX_W      = $clog2(NUM_EVT)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         we_i,
  input logic [5:0]                   addr_i,
  input logic [WORD_W_P-1:0]          wdata_i,
  input logic [NUM_EVT-1:0]           status_q,
  input logic [NUM_EVT-1:0]           set_vec,
  input logic [NUM_GRP_P*NUM_EVT-1:0] mask_flat,
  input logic [NUM_GRP_P-1:0]         irq_o,
  input logic [NUM_GRP_P-1:0]         pend_valid_o,
  input logic [NUM_GRP_P*IDX_W-1:0]   pend_idx_o
);
  assert_set_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  for (genvar w = 0; w < NUM_WORDS_P; w++) begin : g_w
    assert_w1c_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == 6'(4*w)) |=>
      ((status_q[w*WORD_W_P +: WORD_W_P] & $past(wdata_i)
        & ~$past(set_vec[w*WORD_W_P +: WORD_W_P])) == '0));

    assert_zero_write_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == 6'(4*w) && wdata_i == '0) |=>
      (status_q[w*WORD_W_P +: WORD_W_P] ==
       $past(status_q[w*WORD_W_P +: WORD_W_P] | set_vec[w*WORD_W_P +: WORD_W_P])));
  end

  for (genvar g = 0; g < NUM_GRP_P; g++) begin : g_g
    assert_irq_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_o[g] == $past(|(status_q & mask_flat[g*NUM_EVT +: NUM_EVT]))));

    assert_valid_tracks_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_valid_o[g] == irq_o[g]);

    assert_idx_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_valid_o[g] |-> (32'(pend_idx_o[g*IDX_W +: IDX_W]) < NUM_EVT));
  end
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .WORD_W_P    (WORD_W_P),
  .NUM_WORDS_P (NUM_WORDS_P),
  .NUM_GRP_P   (NUM_GRP_P)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .status_q     (status_q),
  .set_vec      (set_vec),
  .mask_flat    (mask_flat),
  .irq_o        (irq_o),
  .pend_valid_o (pend_valid_o),
  .pend_idx_o   (pend_idx_o)
);

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
  localparam int NE = 96;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NE-1:0] event_i;
  logic          we_i;
  logic [5:0]    addr_i;
  logic [31:0]   wdata_i;
  logic [31:0]   rdata_o;
  logic [2:0]    irq_o;
  logic [2:0]    pend_valid_o;
  logic [20:0]   pend_idx_o;

  logic [NE-1:0] ev_pulse = '0;
  logic [NE-1:0] ev_hold  = '0;
  assign event_i = ev_pulse | ev_hold;

  evt_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .event_i(event_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .pend_valid_o(pend_valid_o), .pend_idx_o(pend_idx_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          sel;   // 0 irq, 1 rdata, 2..4 pend of line sel-2
    int          due;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  always @(posedge clk) cyc++;

  // monitor
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [31:0] act;
        logic [31:0] exp;
        exp = q[i].exp;
        case (q[i].sel)
          0:       act = {29'd0, irq_o};
          1:       act = rdata_o;
          default: begin
            act = {24'd0, pend_valid_o[q[i].sel-2], pend_idx_o[(q[i].sel-2)*7 +: 7]};
            if (!exp[7]) begin act[6:0] = '0; end
          end
        endcase
        n_chk++;
        if (act !== exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d cyc=%0d act=%h exp=%h", q[i].tag, q[i].sel, cyc, act, exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic push(input int sel, input int due, input logic [31:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.due = due; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #2;
    we_i = 1'b0; ev_pulse = '0;
  endtask

  task automatic apply(input bit we, input logic [5:0] a, input logic [31:0] d,
                       input logic [NE-1:0] ev);
    tick();
    we_i = we; addr_i = a; wdata_i = d; ev_pulse = ev;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    tick();
    addr_i = a;
    push(1, cyc, exp, tag);
  endtask

  function automatic logic [31:0] pv(input int idx);
    return {24'd0, 1'b1, 7'(idx)};
  endfunction

  function automatic logic [NE-1:0] ev(input int e);
    return NE'(1) << e;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    we_i = 0; addr_i = '0; wdata_i = '0;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;

    // R1 reset state
    rd(6'h00, 32'h0, "R1 status0");
    push(0, cyc, 32'h0, "R1 irq");
    push(2, cyc, 32'h0, "R1 pend A");
    push(3, cyc, 32'h0, "R1 pend B");
    push(4, cyc, 32'h0, "R1 pend C");
    rd(6'h10, 32'h0, "R1 maskA0");
    rd(6'h38, 32'h0, "R1 maskC2");

    // R5 mask write/readback
    apply(1, 6'h10, 32'h0000_0020, '0);
    rd(6'h10, 32'h0000_0020, "R5 maskA0 readback");

    // R2/R6 event 5 -> line A, one-edge latency
    apply(0, 6'h00, 32'h0, ev(5));
    push(0, cyc + 1, 32'h0, "R6 irq not early");
    push(0, cyc + 2, 32'h1, "R6 irq A");
    push(2, cyc + 2, pv(5), "R7 pend A=5");
    push(3, cyc + 2, 32'h0, "R8 pend B none");
    rd(6'h00, 32'h0000_0020, "R2 status0 bit5");

    // R7 masked event does not win priority
    apply(0, 6'h00, 32'h0, ev(3));
    push(2, cyc + 2, pv(5), "R7 masked bit3 ignored");
    rd(6'h00, 32'h0000_0028, "R2 status0 bits3,5");
    apply(1, 6'h10, 32'h0000_0028, '0);
    push(2, cyc + 2, pv(3), "R7 lowest first");

    // R8 one event to two lines
    apply(1, 6'h28, 32'h0000_0040, '0);
    apply(1, 6'h38, 32'h0000_0040, '0);
    apply(0, 6'h00, 32'h0, ev(70));
    push(0, cyc + 2, 32'h7, "R8 irq all");
    push(3, cyc + 2, pv(70), "R8 pend B=70");
    push(4, cyc + 2, pv(70), "R8 pend C=70");
    push(2, cyc + 2, pv(3), "R7 pend A kept 3");
    rd(6'h08, 32'h0000_0040, "R2 status2 bit6");

    // R3 write-zero and write-one-to-clear
    apply(1, 6'h00, 32'h0, '0);
    rd(6'h00, 32'h0000_0028, "R3 zero write no effect");
    apply(1, 6'h00, 32'h0000_0008, '0);
    push(2, cyc + 2, pv(5), "R3 pend A after clear");
    rd(6'h00, 32'h0000_0020, "R3 bit3 cleared");

    // R4 set wins over clear
    apply(1, 6'h00, 32'h0000_0020, ev(5));
    rd(6'h00, 32'h0000_0020, "R4 set wins");

    // R2 held level sets once
    tick(); ev_hold = ev(40);
    rd(6'h04, 32'h0000_0100, "R2 held level set");
    apply(1, 6'h04, 32'h0000_0100, '0);
    rd(6'h04, 32'h0, "R2 cleared while held");
    tick(); tick();
    rd(6'h04, 32'h0, "R2 held no re-set");
    tick(); ev_hold = '0;
    tick();
    apply(0, 6'h00, 32'h0, ev(40));
    rd(6'h04, 32'h0000_0100, "R2 re-rise sets");

    // R5 unmapped word
    apply(1, 6'h0C, 32'hFFFF_FFFF, '0);
    rd(6'h00, 32'h0000_0020, "R5 unmapped write ignored");
    apply(1, 6'h1C, 32'hFFFF_FFFF, '0);
    rd(6'h1C, 32'h0, "R5 unmapped read zero");
    rd(6'h14, 32'h0, "R5 maskA1 untouched");

    // R6 clear everything, lines drop
    apply(1, 6'h00, 32'hFFFF_FFFF, '0);
    apply(1, 6'h04, 32'hFFFF_FFFF, '0);
    apply(1, 6'h08, 32'hFFFF_FFFF, '0);
    push(0, cyc + 2, 32'h0, "R6 irq low after clear");
    push(2, cyc + 2, 32'h0, "R7 pend A invalid");
    repeat (5) tick();

    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard left %0d items", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule